// File: doc/BRIEF.md
# Mesh Coordinate Route Selector

This block decides which output port of a mesh router a packet leaves by. It takes the destination latitude and longitude carried in the head flit of a packet and compares them with the router's own latitude and longitude. From that comparison it produces a one-hot port select. One bit of the select means local delivery: the packet has arrived and stays at this node. Comparisons are unsigned.

A build parameter picks the router shape. In the four-port shape, latitude is resolved before longitude, and only the four cardinal ports and local can be chosen. In the eight-port shape, latitude and longitude are compared together, so a packet that is off in both axes goes straight to one of four diagonal ports. Only a head flit is routed. Its result is stored in a register for each virtual channel. The body and tail flits of the same packet on that channel reuse the stored result, so the coordinate bits they carry have no effect.

Top module: `coord_route_unit`

## Requirements
- R1: When a head flit's destination latitude and longitude both equal the router's own, the select is bit 0 (local) alone, in both shapes.
- R2: Four-port shape: when the destination latitude is above the local one, the select is bit 4 (west); when below, bit 2 (east). This holds whatever the longitudes are.
- R3: Four-port shape: when the latitudes match, a destination longitude above the local one gives bit 3 (south) and one below gives bit 1 (north).
- R4: Eight-port shape: when the longitudes match, a higher destination latitude gives bit 1 (north) and a lower one gives bit 3 (south).
- R5: Eight-port shape: when the latitudes match, a lower destination longitude gives bit 4 (west) and a higher one gives bit 2 (east).
- R6: Eight-port shape, when both axes differ: higher latitude with higher longitude gives bit 5 (north-east), higher with lower gives bit 6 (north-west), lower with higher gives bit 7 (south-east), and lower with lower gives bit 8 (south-west).
- R7: While `in_valid` is high, exactly one bit of `out_sel` is set. While `in_valid` is low, `out_sel` is all zeros. The output is combinational from the inputs and the stored routes.
- R8: Flit bit 62 set marks a head flit. The destination latitude sits in bits 3:0 and the destination longitude in bits 7:4. A valid head flit's select is stored for its channel at the clock edge. A valid flit with bit 62 clear outputs the select stored for its channel, and its coordinate bits and the current `my_lat`/`my_long` are ignored.
- R9: A head flit on one virtual channel leaves the stored selects of all other channels unchanged.
- R10: After reset, every channel's stored select is local (bit 0), so a non-head flit on a channel that has had no head since reset selects local.
- R11: Coordinates are compared as unsigned 4-bit numbers, so a value of 15 is above a value of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the stored routes update on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the stored routes |
| in_valid | input | 1 | A flit is present this cycle |
| in_vc | input | VC_W (2) | Virtual channel of the flit |
| in_flit | input | FLIT_W (64) | Flit word; bit 62 marks a head, bits 3:0 and 7:4 hold the destination |
| my_lat | input | COORD_W (4) | Latitude of this router |
| my_long | input | COORD_W (4) | Longitude of this router |
| out_sel | output | PORTS (9 or 5) | One-hot port select: local, N, E, S, W, then NE, NW, SE, SW |

## Verification
The bench builds two copies side by side and drives them with the same flits. One copy uses the eight-port shape (DIAG=1) and the other the four-port shape (DIAG=0), both with four virtual channels. This puts the diagonal decisions and the latitude-first decisions under the same stimulus. It also shows that a destination off in both axes goes diagonal in one copy and west or east in the other. With four channels, heads and bodies can be interleaved across channels, which exercises the per-channel hold and the isolation between channels. The 4-bit coordinates let the random stimulus reach equality on either axis often, as well as the 0 and 15 extremes.

// File: rtl/route_pkg.sv
package route_pkg;

  localparam int PORT_LOCAL = 0;
  localparam int PORT_N     = 1;
  localparam int PORT_E     = 2;
  localparam int PORT_S     = 3;
  localparam int PORT_W     = 4;
  localparam int PORT_NE    = 5;
  localparam int PORT_NW    = 6;
  localparam int PORT_SE    = 7;
  localparam int PORT_SW    = 8;
  localparam int PORTS_MAX  = 9;

  typedef logic [PORTS_MAX-1:0] sel_t;

  // Outcome of comparing destination against local position on both axes.
  typedef struct packed {
    logic lat_gt;
    logic lat_lt;
    logic long_gt;
    logic long_lt;
  } cmp_t;

  function automatic sel_t onehot_of(input int idx);
    sel_t s;
    s = '0;
    s[idx] = 1'b1;
    return s;
  endfunction

  // Latitude settles first, longitude only once latitude matches.
  function automatic sel_t route_cardinal(input cmp_t c);
    if (c.lat_gt)       return onehot_of(PORT_W);
    else if (c.lat_lt)  return onehot_of(PORT_E);
    else if (c.long_gt) return onehot_of(PORT_S);
    else if (c.long_lt) return onehot_of(PORT_N);
    else                return onehot_of(PORT_LOCAL);
  endfunction

  // Both axes resolved together; off in both picks a diagonal.
  function automatic sel_t route_diagonal(input cmp_t c);
    logic lat_eq;
    logic long_eq;
    lat_eq  = !c.lat_gt && !c.lat_lt;
    long_eq = !c.long_gt && !c.long_lt;
    if (lat_eq && long_eq)       return onehot_of(PORT_LOCAL);
    else if (long_eq)            return onehot_of(c.lat_gt ? PORT_N : PORT_S);
    else if (lat_eq)             return onehot_of(c.long_gt ? PORT_E : PORT_W);
    else if (c.lat_gt)           return onehot_of(c.long_gt ? PORT_NE : PORT_NW);
    else                         return onehot_of(c.long_gt ? PORT_SE : PORT_SW);
  endfunction

endpackage

// File: rtl/route_compare.sv
module route_compare #(
  parameter int COORD_W = 4
) (
  input  logic [COORD_W-1:0] dst_lat,
  input  logic [COORD_W-1:0] dst_long,
  input  logic [COORD_W-1:0] here_lat,
  input  logic [COORD_W-1:0] here_long,
  output route_pkg::cmp_t    cmp
);
  // Unsigned magnitude comparisons on both axes.
  always_comb begin
    cmp.lat_gt  = dst_lat  > here_lat;
    cmp.lat_lt  = dst_lat  < here_lat;
    cmp.long_gt = dst_long > here_long;
    cmp.long_lt = dst_long < here_long;
  end
endmodule

// File: rtl/route_decode.sv
module route_decode #(
  parameter int DIAG  = 1,
  parameter int PORTS = 9
) (
  input  route_pkg::cmp_t   cmp,
  output logic [PORTS-1:0]  sel
);
  import route_pkg::*;

  sel_t full_sel;

  generate
    if (DIAG != 0) begin : g_eight
      always_comb full_sel = route_diagonal(cmp);
    end else begin : g_four
      always_comb full_sel = route_cardinal(cmp);
    end
  endgenerate

  assign sel = full_sel[PORTS-1:0];

  // Any computed route must name one port only.
  always_comb begin
    a_dec_onehot_r7: assert ($countones(sel) == 1 || $isunknown(cmp))
      else $error("decoder produced a non one-hot route");
  end
endmodule

// File: rtl/route_vc_store.sv
module route_vc_store #(
  parameter int NUM_VC = 4,
  parameter int W      = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(NUM_VC)-1:0]  wr_idx,
  input  logic [W-1:0]               wr_data,
  input  logic [$clog2(NUM_VC)-1:0]  rd_idx,
  output logic [W-1:0]               rd_data
);
  localparam logic [W-1:0] RESET_ROUTE = W'(1);

  logic [W-1:0] route_q [NUM_VC];

  generate
    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      always_ff @(posedge clk) begin
        if (!rst_n)
          route_q[v] <= RESET_ROUTE;
        else if (wr_en && wr_idx == v[$clog2(NUM_VC)-1:0])
          route_q[v] <= wr_data;
      end
    end
  endgenerate

  assign rd_data = route_q[rd_idx];
endmodule

// File: rtl/coord_route_unit.sv
module coord_route_unit #(
  parameter int DIAG     = 1,
  parameter int FLIT_W   = 64,
  parameter int COORD_W  = 4,
  parameter int NUM_VC   = 4,
  parameter int LAT_LSB  = 0,
  parameter int LONG_LSB = 4,
  parameter int HEAD_BIT = 62,
  localparam int VC_W    = $clog2(NUM_VC),
  localparam int PORTS   = (DIAG != 0) ? 9 : 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [VC_W-1:0]    in_vc,
  input  logic [FLIT_W-1:0]  in_flit,
  input  logic [COORD_W-1:0] my_lat,
  input  logic [COORD_W-1:0] my_long,
  output logic [PORTS-1:0]   out_sel
);
  import route_pkg::*;

  // Named internal events, visible to the assertions below.
  logic               is_head;
  logic               head_take;
  logic [COORD_W-1:0] dst_lat;
  logic [COORD_W-1:0] dst_long;
  cmp_t               cmp;
  logic               at_target;
  logic [PORTS-1:0]   fresh_sel;
  logic [PORTS-1:0]   held_sel;

  assign is_head   = in_flit[HEAD_BIT];
  assign head_take = in_valid && is_head;
  assign dst_lat   = in_flit[LAT_LSB  +: COORD_W];
  assign dst_long  = in_flit[LONG_LSB +: COORD_W];
  assign at_target = (dst_lat == my_lat) && (dst_long == my_long);

  route_compare #(.COORD_W(COORD_W)) u_cmp (
    .dst_lat   (dst_lat),
    .dst_long  (dst_long),
    .here_lat  (my_lat),
    .here_long (my_long),
    .cmp       (cmp)
  );

  route_decode #(.DIAG(DIAG), .PORTS(PORTS)) u_dec (
    .cmp (cmp),
    .sel (fresh_sel)
  );

  route_vc_store #(.NUM_VC(NUM_VC), .W(PORTS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (head_take),
    .wr_idx  (in_vc),
    .wr_data (fresh_sel),
    .rd_idx  (in_vc),
    .rd_data (held_sel)
  );

  always_comb begin
    if (!in_valid)    out_sel = '0;
    else if (is_head) out_sel = fresh_sel;
    else              out_sel = held_sel;
  end

  // Assertions

  p_onehot_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $countones(out_sel) == 1)
    else $error("select not one-hot while valid");

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> out_sel == '0)
    else $error("select active while idle");

  p_hold_local_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (head_take && at_target) |-> out_sel[PORT_LOCAL])
    else $error("arrived head not delivered locally");

  p_body_follows_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_head && $past(rst_n) && $past(head_take) && in_vc == $past(in_vc))
      |-> out_sel == $past(out_sel))
    else $error("body flit left the head's route");

  generate
    if (DIAG != 0) begin : g_chk_eight
      p_diag_when_both_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (head_take && dst_lat != my_lat && dst_long != my_long) |-> out_sel[8:5] != '0)
        else $error("off in both axes but no diagonal chosen");
    end else begin : g_chk_four
      p_lat_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (head_take && dst_lat != my_lat) |-> (out_sel[PORT_E] || out_sel[PORT_W]))
        else $error("latitude mismatch not resolved first");
    end
  endgenerate
endmodule

// File: tb/coord_route_unit_test.sv
module coord_route_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVC        = 4;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_vc;
  logic [63:0] in_flit;
  logic [3:0]  my_lat, my_long;
  logic [8:0]  sel8;
  logic [4:0]  sel4;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [8:0] mdl8 [NVC];
  logic [8:0] mdl4 [NVC];

  always #(CLK_PERIOD/2) clk = ~clk;

  coord_route_unit #(.DIAG(1), .NUM_VC(NVC)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
    .in_flit(in_flit), .my_lat(my_lat), .my_long(my_long), .out_sel(sel8));

  coord_route_unit #(.DIAG(0), .NUM_VC(NVC)) uut_q (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc),
    .in_flit(in_flit), .my_lat(my_lat), .my_long(my_long), .out_sel(sel4));

  // Expected route, eight-port: classify each axis as -1/0/+1.
  function automatic logic [8:0] exp8(input logic [3:0] dl, dg, ml, mg);
    int sl, sg;
    sl = (dl > ml) ? 1 : (dl < ml) ? -1 : 0;
    sg = (dg > mg) ? 1 : (dg < mg) ? -1 : 0;
    case ({sl, sg})
      {0, 0}:   return 9'b000000001;
      {1, 0}:   return 9'b000000010;
      {-1, 0}:  return 9'b000001000;
      {0, 1}:   return 9'b000000100;
      {0, -1}:  return 9'b000010000;
      {1, 1}:   return 9'b000100000;
      {1, -1}:  return 9'b001000000;
      {-1, 1}:  return 9'b010000000;
      default:  return 9'b100000000;
    endcase
  endfunction

  // Expected route, four-port: latitude decides first.
  function automatic logic [8:0] exp4(input logic [3:0] dl, dg, ml, mg);
    if (dl != ml) return (dl > ml) ? 9'b000010000 : 9'b000000100;
    if (dg != mg) return (dg > mg) ? 9'b000001000 : 9'b000000010;
    return 9'b000000001;
  endfunction

  task automatic check(input string tag, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Drive at the falling edge, check mid-cycle, then let the rising edge store.
  task automatic send(input string tag, input bit valid, input logic [1:0] vc, input bit head,
                      input logic [3:0] dl, dg, ml, mg);
    logic [63:0] f;
    logic [8:0]  e8, e4;
    @(negedge clk);
    f = {$urandom, $urandom};
    f[3:0] = dl;
    f[7:4] = dg;
    f[62]  = head;
    in_valid = valid; in_vc = vc; in_flit = f; my_lat = ml; my_long = mg;
    if (!valid) begin
      e8 = '0; e4 = '0;
    end else if (head) begin
      e8 = exp8(dl, dg, ml, mg);
      e4 = exp4(dl, dg, ml, mg);
    end else begin
      e8 = mdl8[vc];
      e4 = mdl4[vc];
    end
    #2;
    check({tag, " eight-port"}, sel8, e8);
    check({tag, " four-port"}, {4'b0, sel4}, e4);
    if (valid && head) begin
      mdl8[vc] = e8;
      mdl4[vc] = e4;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; in_vc = '0; in_flit = '0; my_lat = '0; my_long = '0;
    for (int v = 0; v < NVC; v++) begin mdl8[v] = 9'b1; mdl4[v] = 9'b1; end
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    check("R7 reset idle", sel8, 9'b0);
    rst_n = 1'b1;

    // R10: body before any head on each channel
    send("R10 body after reset", 1, 2'd3, 0, 4'd9, 4'd1, 4'd5, 4'd5);
    send("R7 idle zero", 0, 2'd0, 1, 4'd9, 4'd1, 4'd5, 4'd5);
    // R1 arrival
    send("R1 arrived", 1, 2'd0, 1, 4'd7, 4'd7, 4'd7, 4'd7);
    // R4 / R3 same-longitude and same-latitude cases
    send("R4 north", 1, 2'd0, 1, 4'd9, 4'd5, 4'd5, 4'd5);
    send("R4 south", 1, 2'd0, 1, 4'd2, 4'd5, 4'd5, 4'd5);
    send("R5 R3 west/north", 1, 2'd0, 1, 4'd5, 4'd1, 4'd5, 4'd5);
    send("R5 R3 east/south", 1, 2'd0, 1, 4'd5, 4'd12, 4'd5, 4'd5);
    // R6 / R2 both off
    send("R6 R2 ne", 1, 2'd1, 1, 4'd9, 4'd9, 4'd5, 4'd5);
    send("R6 R2 nw", 1, 2'd1, 1, 4'd9, 4'd1, 4'd5, 4'd5);
    send("R6 R2 se", 1, 2'd1, 1, 4'd1, 4'd9, 4'd5, 4'd5);
    send("R6 R2 sw", 1, 2'd1, 1, 4'd1, 4'd1, 4'd5, 4'd5);
    // R11 extremes
    send("R11 max over min", 1, 2'd2, 1, 4'd15, 4'd15, 4'd0, 4'd0);
    send("R11 min under max", 1, 2'd2, 1, 4'd0, 4'd0, 4'd15, 4'd15);
    // R8 body ignores its own coordinates; R9 other channels untouched
    send("R8 head vc0", 1, 2'd0, 1, 4'd3, 4'd12, 4'd8, 4'd8);
    send("R8 body vc0", 1, 2'd0, 0, 4'd8, 4'd8, 4'd8, 4'd8);
    send("R9 head vc1", 1, 2'd1, 1, 4'd14, 4'd14, 4'd2, 4'd2);
    send("R9 body vc0", 1, 2'd0, 0, 4'd0, 4'd15, 4'd1, 4'd1);
    send("R9 body vc2", 1, 2'd2, 0, 4'd5, 4'd5, 4'd5, 4'd5);

    // Random traffic, biased towards equal axes
    for (int i = 0; i < 600; i++) begin
      logic [3:0] ml, mg, dl, dg;
      ml = 4'($urandom); mg = 4'($urandom);
      dl = ($urandom % 3 == 0) ? ml : 4'($urandom);
      dg = ($urandom % 3 == 0) ? mg : 4'($urandom);
      send("R1-6 R8 R9 random", ($urandom % 8) != 0, 2'($urandom), ($urandom % 2) == 0,
           dl, dg, ml, mg);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule